// File: doc/BRIEF.md
# Banked Memory Decoder with Display Register Capture

This block sits between a CPU's 16-bit memory bus and four targets: main RAM, a 2 KB boot PROM, a 1 KB disk buffer RAM and the register load port of a display controller. It holds a small control register written from a parallel output port. Three bits of that register decide where each access goes. For every bus cycle the block raises the chip select of the target, forms the target's local address, gates the write enable and steers the target's read data back onto the bus. The memories are outside the block.

Control bit 2 maps the boot PROM over the lowest 16 KB for reads and makes writes there vanish. Control bit 0 disables the lowest 16 KB of RAM, and it also turns every memory write into a display register load. In that load the CPU address supplies a 12-bit value and the two low data bits, in swapped order, give a 2-bit register select. Control bit 4, when cleared, replaces RAM in the third 16 KB bank with the disk buffer.

Top module: `mdec_bank_decoder`

## Requirements
- R1: After reset the control register holds 0x14 (bit 2 and bit 4 set, bit 0 clear), so a read of address 0x0000 returns boot PROM data.
- R2: With control bit 2 set, a read in 0x0000–0x3FFF asserts prom_cs with prom_addr = bus_addr[10:0] and returns prom_rdata; RAM and disk buffer stay deselected.
- R3: With control bit 2 set, a write in 0x0000–0x3FFF asserts no chip select and no write enable.
- R4: With control bit 0 set and bit 2 clear, a read in 0x0000–0x3FFF returns 0xFF with no chip select, and a write there asserts no chip select.
- R5: When bits 2 and 0 are both set, reads in 0x0000–0x3FFF return boot PROM data (PROM has priority over the bank disable).
- R6: With control bit 4 clear, reads and writes in 0x8000–0xBFFF assert dbuf_cs (dbuf_we on writes) with dbuf_addr = bus_addr[9:0] and return dbuf_rdata on reads; ram_cs stays low.
- R7: While control bit 0 is set, every memory write pulses crt_ld in the same cycle as bus_wr, with crt_sel = {bus_wdata[0], bus_wdata[1]} and crt_val = bus_addr[11:0], whatever the region.
- R8: With control bit 0 clear, crt_ld stays low and crt_sel and crt_val read zero.
- R9: All other accesses go to main RAM: ram_cs (ram_we on writes) with ram_addr = bus_addr, and reads return ram_rdata.
- R10: At most one chip select is high; with neither bus_rd nor bus_wr asserted no chip select is high and bus_rdata is 0x00.
- R11: ctl_wdata is loaded into the control register on a clock edge with ctl_we high, and from that edge on it governs decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data |
| bus_addr | input | 16 | CPU memory address |
| bus_rd | input | 1 | CPU memory read |
| bus_wr | input | 1 | CPU memory write |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data returned to the CPU |
| mem_wdata | output | 8 | Write data to all memories |
| ram_cs | output | 1 | Main RAM select |
| ram_we | output | 1 | Main RAM write enable |
| ram_addr | output | 16 | Main RAM address |
| ram_rdata | input | 8 | Main RAM read data |
| prom_cs | output | 1 | Boot PROM select |
| prom_addr | output | 11 | Boot PROM address |
| prom_rdata | input | 8 | Boot PROM read data |
| dbuf_cs | output | 1 | Disk buffer select |
| dbuf_we | output | 1 | Disk buffer write enable |
| dbuf_addr | output | 10 | Disk buffer address |
| dbuf_rdata | input | 8 | Disk buffer read data |
| crt_ld | output | 1 | Display register load strobe |
| crt_sel | output | 2 | Display register select |
| crt_val | output | 12 | Display register value |

## Verification
The hardest case to reach is a write that lands in the disk buffer and is also captured as a display register load. It needs bit 0 set and bit 4 cleared together, while reset leaves bit 4 set and bit 0 clear. The bench first writes the control register and then issues writes in the low, buffer and high banks with data whose two low bits differ. That shows the swapped select, the address-derived value and the disk buffer write all in one cycle. A combined PROM-plus-disable setting is also loaded to show the priority between the two low-bank controls.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
   typedef enum logic [1:0] {
      TGT_RAM  = 2'd0,
      TGT_PROM = 2'd1,
      TGT_DBUF = 2'd2,
      TGT_OFF  = 2'd3
   } mdec_tgt_e;
endpackage

// File: rtl/mdec_ctl_reg.sv
module mdec_ctl_reg #(
   parameter int          CTL_W     = 8,
   parameter logic [7:0]  CTL_RESET = 8'h14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= CTL_RESET[CTL_W-1:0];
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/mdec_region_decode.sv
module mdec_region_decode
   import mdec_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int CTL_W     = 8,
   parameter int BIT_OFF   = 0,
   parameter int BIT_PROM  = 2,
   parameter int BIT_DBUF  = 4,
   parameter int LOW_BANK  = 0,
   parameter int DBUF_BANK = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CTL_W-1:0]  ctl,
   output mdec_tgt_e         tgt
);
   localparam int BANK_W = 2;
   logic [BANK_W-1:0] bank;
   assign bank = addr[ADDR_W-1 -: BANK_W];

   always_comb begin
      tgt = TGT_RAM;
      if (bank == BANK_W'(LOW_BANK)) begin
         if (ctl[BIT_PROM])     tgt = TGT_PROM;   // PROM wins over disable
         else if (ctl[BIT_OFF]) tgt = TGT_OFF;
      end else if (bank == BANK_W'(DBUF_BANK) && !ctl[BIT_DBUF]) begin
         tgt = TGT_DBUF;
      end
   end
endmodule

// File: rtl/mdec_target_ctl.sv
module mdec_target_ctl
   import mdec_pkg::*;
#(
   parameter int          ADDR_W  = 16,
   parameter int          DATA_W  = 8,
   parameter int          PROM_AW = 11,
   parameter int          DBUF_AW = 10,
   parameter logic [7:0]  FILL    = 8'hFF
) (
   input  mdec_tgt_e           tgt,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                rd,
   input  logic                wr,
   input  logic [DATA_W-1:0]   ram_rdata,
   input  logic [DATA_W-1:0]   prom_rdata,
   input  logic [DATA_W-1:0]   dbuf_rdata,
   output logic                ram_cs,
   output logic                ram_we,
   output logic [ADDR_W-1:0]   ram_addr,
   output logic                prom_cs,
   output logic [PROM_AW-1:0]  prom_addr,
   output logic                dbuf_cs,
   output logic                dbuf_we,
   output logic [DBUF_AW-1:0]  dbuf_addr,
   output logic [DATA_W-1:0]   rdata
);
   logic acc;
   assign acc = rd | wr;

   assign ram_addr  = addr;
   assign prom_addr = addr[PROM_AW-1:0];
   assign dbuf_addr = addr[DBUF_AW-1:0];

   always_comb begin
      ram_cs  = 1'b0;
      ram_we  = 1'b0;
      prom_cs = 1'b0;
      dbuf_cs = 1'b0;
      dbuf_we = 1'b0;
      rdata   = '0;
      unique case (tgt)
         TGT_RAM: begin
            ram_cs = acc;
            ram_we = wr;
            if (rd) rdata = ram_rdata;
         end
         TGT_PROM: begin
            prom_cs = rd;               // read-only: writes are dropped
            if (rd) rdata = prom_rdata;
         end
         TGT_DBUF: begin
            dbuf_cs = acc;
            dbuf_we = wr;
            if (rd) rdata = dbuf_rdata;
         end
         TGT_OFF: begin
            if (rd) rdata = FILL[DATA_W-1:0];
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdec_reg_load.sv
module mdec_reg_load #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int VAL_W    = 12,
   parameter int SEL_W    = 2,
   parameter bit SEL_SWAP = 1'b1
) (
   input  logic              enable,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ld,
   output logic [SEL_W-1:0]  sel,
   output logic [VAL_W-1:0]  val
);
   logic [SEL_W-1:0] sel_raw;

   generate
      if (SEL_SWAP) begin : g_swap
         for (genvar i = 0; i < SEL_W; i++) begin : g_bit
            assign sel_raw[i] = wdata[SEL_W-1-i];
         end
      end else begin : g_straight
         assign sel_raw = wdata[SEL_W-1:0];
      end
   endgenerate

   assign ld  = enable & wr;
   assign sel = ld ? sel_raw : '0;
   assign val = ld ? addr[VAL_W-1:0] : '0;
endmodule

// File: rtl/mdec_bank_decoder.sv
module mdec_bank_decoder
   import mdec_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter int          PROM_AW   = 11,
   parameter int          DBUF_AW   = 10,
   parameter int          CTL_W     = 8,
   parameter int          VAL_W     = 12,
   parameter int          SEL_W     = 2,
   parameter int          BIT_OFF   = 0,
   parameter int          BIT_PROM  = 2,
   parameter int          BIT_DBUF  = 4,
   parameter int          LOW_BANK  = 0,
   parameter int          DBUF_BANK = 2,
   parameter logic [7:0]  CTL_RESET = 8'h14,
   parameter logic [7:0]  FILL      = 8'hFF,
   parameter bit          SEL_SWAP  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_we,
   input  logic [CTL_W-1:0]   ctl_wdata,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               ram_cs,
   output logic               ram_we,
   output logic [ADDR_W-1:0]  ram_addr,
   input  logic [DATA_W-1:0]  ram_rdata,
   output logic               prom_cs,
   output logic [PROM_AW-1:0] prom_addr,
   input  logic [DATA_W-1:0]  prom_rdata,
   output logic               dbuf_cs,
   output logic               dbuf_we,
   output logic [DBUF_AW-1:0] dbuf_addr,
   input  logic [DATA_W-1:0]  dbuf_rdata,
   output logic               crt_ld,
   output logic [SEL_W-1:0]   crt_sel,
   output logic [VAL_W-1:0]   crt_val
);
   localparam int BANK_AW = ADDR_W - 2;

   generate
      if (PROM_AW > BANK_AW)  begin : g_bad_prom  $error("PROM_AW exceeds bank size"); end
      if (DBUF_AW > BANK_AW)  begin : g_bad_dbuf  $error("DBUF_AW exceeds bank size"); end
      if (VAL_W > ADDR_W)     begin : g_bad_val   $error("VAL_W exceeds ADDR_W"); end
      if (SEL_W > DATA_W)     begin : g_bad_sel   $error("SEL_W exceeds DATA_W"); end
      if (BIT_OFF >= CTL_W || BIT_PROM >= CTL_W || BIT_DBUF >= CTL_W)
                              begin : g_bad_bit   $error("control bit out of range"); end
      if (LOW_BANK > 3 || DBUF_BANK > 3 || LOW_BANK == DBUF_BANK)
                              begin : g_bad_bank  $error("bank index invalid"); end
   endgenerate

   logic [CTL_W-1:0] ctl_q;
   mdec_tgt_e        tgt;

   mdec_ctl_reg #(.CTL_W(CTL_W), .CTL_RESET(CTL_RESET)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .q(ctl_q)
   );

   mdec_region_decode #(
      .ADDR_W(ADDR_W), .CTL_W(CTL_W), .BIT_OFF(BIT_OFF), .BIT_PROM(BIT_PROM),
      .BIT_DBUF(BIT_DBUF), .LOW_BANK(LOW_BANK), .DBUF_BANK(DBUF_BANK)
   ) u_dec (
      .addr(bus_addr), .ctl(ctl_q), .tgt(tgt)
   );

   mdec_target_ctl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROM_AW(PROM_AW),
      .DBUF_AW(DBUF_AW), .FILL(FILL)
   ) u_tgt (
      .tgt(tgt), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
      .ram_rdata(ram_rdata), .prom_rdata(prom_rdata), .dbuf_rdata(dbuf_rdata),
      .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
      .prom_cs(prom_cs), .prom_addr(prom_addr),
      .dbuf_cs(dbuf_cs), .dbuf_we(dbuf_we), .dbuf_addr(dbuf_addr),
      .rdata(bus_rdata)
   );

   mdec_reg_load #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VAL_W(VAL_W), .SEL_W(SEL_W),
      .SEL_SWAP(SEL_SWAP)
   ) u_rl (
      .enable(ctl_q[BIT_OFF]), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .ld(crt_ld), .sel(crt_sel), .val(crt_val)
   );

   assign mem_wdata = bus_wdata;
endmodule

// File: rtl/mdec_checker.sv
module mdec_checker #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int CTL_W    = 8,
   parameter int BIT_OFF  = 0,
   parameter int BIT_PROM = 2,
   parameter int BIT_DBUF = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_we,
   input logic [CTL_W-1:0]  ctl_wdata,
   input logic [CTL_W-1:0]  ctl_q,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              ram_cs,
   input logic              prom_cs,
   input logic              dbuf_cs,
   input logic              crt_ld
);
   logic low_bank;
   assign low_bank = (bus_addr[ADDR_W-1 -: 2] == 2'd0);

   assert_one_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_cs, prom_cs, dbuf_cs}));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |-> !(ram_cs || prom_cs || dbuf_cs));

   assert_prom_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      prom_cs |-> (bus_rd && !bus_wr));

   assert_ld_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      crt_ld |-> (bus_wr && ctl_q[BIT_OFF]));

   assert_no_ld_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[BIT_OFF] |-> !crt_ld);

   assert_dbuf_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dbuf_cs |-> (bus_addr[ADDR_W-1 -: 2] == 2'd2 && !ctl_q[BIT_DBUF]));

   assert_low_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && low_bank && ctl_q[BIT_OFF] && !ctl_q[BIT_PROM])
         |-> (bus_rdata == '1 && !ram_cs));

   assert_prom_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && low_bank && ctl_q[BIT_PROM]) |-> prom_cs);

   assert_ctl_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (ctl_q == $past(ctl_wdata)));
endmodule

bind mdec_bank_decoder mdec_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W),
   .BIT_OFF(BIT_OFF), .BIT_PROM(BIT_PROM), .BIT_DBUF(BIT_DBUF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
   .ctl_q(ctl_q), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
   .bus_rdata(bus_rdata), .ram_cs(ram_cs), .prom_cs(prom_cs),
   .dbuf_cs(dbuf_cs), .crt_ld(crt_ld)
);

// File: tb/sim_mdec_bank_decoder.sv
module sim_mdec_bank_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = 8'h00;
   logic [15:0] bus_addr = 16'h0000;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata, mem_wdata, ram_rdata, prom_rdata, dbuf_rdata;
   logic        ram_cs, ram_we, prom_cs, dbuf_cs, dbuf_we, crt_ld;
   logic [15:0] ram_addr;
   logic [10:0] prom_addr;
   logic [9:0]  dbuf_addr;
   logic [1:0]  crt_sel;
   logic [11:0] crt_val;

   always #10 clk = ~clk;   // 50 MHz

   // memory models: contents are a function of the local address
   assign ram_rdata  = ram_addr[7:0] ^ ram_addr[15:8];
   assign prom_rdata = ~prom_addr[7:0] ^ {5'b0, prom_addr[10:8]};
   assign dbuf_rdata = dbuf_addr[7:0] + {6'b0, dbuf_addr[9:8]} + 8'h33;

   mdec_bank_decoder u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_wdata(mem_wdata),
      .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_rdata(ram_rdata), .prom_cs(prom_cs), .prom_addr(prom_addr),
      .prom_rdata(prom_rdata), .dbuf_cs(dbuf_cs), .dbuf_we(dbuf_we),
      .dbuf_addr(dbuf_addr), .dbuf_rdata(dbuf_rdata), .crt_ld(crt_ld),
      .crt_sel(crt_sel), .crt_val(crt_val)
   );

   typedef struct {
      logic [7:0]  rdata;
      logic [2:0]  cs;      // {ram, prom, dbuf}
      logic [1:0]  we;      // {ram, dbuf}
      logic        ld;
      logic [1:0]  sel;
      logic [11:0] val;
      string       tag;
   } exp_t;

   exp_t   sb_q[$];
   int     n_checks = 0;
   int     n_fail   = 0;
   bit     done     = 1'b0;
   logic [7:0] shadow_ctl = 8'h14;   // R1 reset value

   // independent expectation from the requirements
   function automatic exp_t model(input logic [7:0] c, input logic [15:0] a,
                                  input logic rd, input logic wr,
                                  input logic [7:0] wd, input string tag);
      exp_t e;
      logic acc = rd | wr;
      e.rdata = 8'h00; e.cs = 3'b000; e.we = 2'b00;
      e.tag = tag;
      if (a[15:14] == 2'b00 && c[2]) begin            // R2 R3 R5
         e.cs[1] = rd;
         if (rd) e.rdata = ~a[7:0] ^ {5'b0, a[10:8]};
      end else if (a[15:14] == 2'b00 && c[0]) begin   // R4
         if (rd) e.rdata = 8'hFF;
      end else if (a[15:14] == 2'b10 && !c[4]) begin  // R6
         e.cs[0] = acc; e.we[0] = wr;
         if (rd) e.rdata = a[7:0] + {6'b0, a[9:8]} + 8'h33;
      end else begin                                   // R9
         e.cs[2] = acc; e.we[1] = wr;
         if (rd) e.rdata = a[7:0] ^ a[15:8];
      end
      e.ld  = c[0] & wr;                               // R7 R8
      e.sel = e.ld ? {wd[0], wd[1]} : 2'b00;
      e.val = e.ld ? a[11:0] : 12'h000;
      return e;
   endfunction

   task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                         input logic [7:0] wd, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
      sb_q.push_back(model(shadow_ctl, a, rd, wr, wd, tag));
   endtask

   task automatic ctl_write(input logic [7:0] v);
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
      shadow_ctl = v;   // R11: in force from the edge just passed
   endtask

   // monitor: compares away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (sb_q.size() > 0) begin
            exp_t e;
            logic [28:0] act, exv;
            e = sb_q.pop_front();
            act = {bus_rdata, ram_cs, prom_cs, dbuf_cs, ram_we, dbuf_we,
                   crt_ld, crt_sel, crt_val};
            exv = {e.rdata, e.cs, e.we, e.ld, e.sel, e.val};
            n_checks++;
            if (act !== exv || ram_addr !== bus_addr ||
                prom_addr !== bus_addr[10:0] || dbuf_addr !== bus_addr[9:0] ||
                mem_wdata !== bus_wdata) begin
               n_fail++;
               $display("FAIL %s addr=%h actual=%h expected=%h", e.tag,
                        bus_addr, act, exv);
            end
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1/R2: reset state maps PROM low
      access(16'h0000, 1, 0, 8'h00, "R1 reset PROM read");
      access(16'h3ABC, 1, 0, 8'h00, "R2 PROM mirror read");
      access(16'h1234, 0, 1, 8'h5A, "R3 PROM write dropped");
      access(16'h8010, 1, 0, 8'h00, "R9 bank2 RAM with bit4 set");
      access(16'h4000, 1, 0, 8'h00, "R9 bank1 RAM read");
      access(16'hC123, 0, 1, 8'hA5, "R9 bank3 RAM write, R8 no load");
      access(16'h5555, 0, 0, 8'h00, "R10 idle");
      // bit0 on, bit4 off, PROM off
      ctl_write(8'h01);
      access(16'h0100, 1, 0, 8'h00, "R4 disabled bank reads FF");
      access(16'h0100, 0, 1, 8'h01, "R4 R7 write to disabled bank loads reg");
      access(16'h8FFF, 0, 1, 8'h02, "R6 R7 dbuf write plus load");
      access(16'hF7A5, 0, 1, 8'h03, "R7 RAM write plus load");
      access(16'h9234, 1, 0, 8'h00, "R6 dbuf read");
      access(16'h2222, 0, 0, 8'hFF, "R10 idle with bit0");
      // priority
      ctl_write(8'h05);
      access(16'h0005, 1, 0, 8'h00, "R5 PROM over disable");
      access(16'h3FFF, 0, 1, 8'h02, "R5 R3 R7 write under PROM");
      // RAM everywhere
      ctl_write(8'h10);
      access(16'h2000, 0, 1, 8'h77, "R9 R8 low RAM write");
      access(16'h0000, 1, 0, 8'h00, "R11 R9 low RAM read after ctl write");
      access(16'h9234, 1, 0, 8'h00, "R9 bank2 RAM");
      // disk buffer with no loads
      ctl_write(8'h00);
      access(16'hA3FF, 1, 0, 8'h00, "R6 dbuf top");
      access(16'h8400, 1, 0, 8'h00, "R6 dbuf wrap");
      access(16'hBC01, 0, 1, 8'h03, "R6 R8 dbuf write");
      ctl_write(8'h04);
      access(16'h07FF, 1, 0, 8'h00, "R11 PROM back in");
      access(16'h0000, 0, 0, 8'h00, "R10 final idle");
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL R10 scoreboard left %0d items, expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule